// File: doc/BRIEF.md
# Parallel Accumulator Adder

This block keeps an n-bit running total in a register and, on command, either adds an operand to it or overwrites it with that operand. The operand bus feeds both a ripple-carry adder, whose other input is the current total, and a bypass path. A multiplexer in front of the register selects the bypass path, the adder output or the register's own content as the next value. The carry out of the top adder bit is captured in a flag register beside the total.

There are two ways to seed the total. An asynchronous clear empties the register at once, after which an ordinary add of the starting value places it in the register. Alternatively, a load strobe writes the operand straight in through the bypass path in one cycle, with no clear needed first.

Top module: `accum_adder`

## Requirements
- R1: While `clr` is high, `acc` and `carry` are 0, and they become 0 as soon as `clr` rises, before any clock edge.
- R2: At a rising `clk` edge with `clr` low, `add_en` high and `load_en` low, `acc` takes the low W bits of `acc + y` and `carry` takes bit W of that (W+1)-bit sum.
- R3: At a rising `clk` edge with `clr` low and `load_en` high, `acc` takes `y` and `carry` becomes 0.
- R4: With `load_en` and `add_en` both high, the load of R3 is performed and the add is not.
- R5: At a rising `clk` edge with `clr` low and both strobes low, `acc` and `carry` keep their values whatever `y` carries.
- R6: After a clear, a single add of a value V leaves `acc` equal to V and `carry` equal to 0.
- R7: When `acc + y` is 2^W or more, `carry` is 1 and `acc` holds the sum minus 2^W, including the case where the sum is exactly 2^W and `acc` becomes 0.
- R8: The width W is the parameter `WIDTH` (default 8); the sum comes from a chain of W one-bit full-adder stages with a carry of 0 into the lowest stage.
- R9: While `clr` is high, rising clock edges leave `acc` and `carry` at 0 whatever the strobes and `y` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register updates on its rising edge |
| clr | input | 1 | Asynchronous clear, active high |
| add_en | input | 1 | Add strobe: total becomes total plus `y` |
| load_en | input | 1 | Load strobe: total becomes `y`; wins over `add_en` |
| y | input | WIDTH | Operand bus |
| acc | output | WIDTH | Registered running total |
| carry | output | 1 | Registered carry out of the last add |

## Verification
The add path is tried with sums well below 2^W, sums just above it and a sum landing exactly on 2^W, which tell apart a dropped carry, a carry that fails to set the flag, and a wrap that leaves stale low bits. Hold cycles with a live, nonzero operand on `y` separate a true hold from an add or load that leaks through, while a cycle with both strobes high checks that the bypass path wins. Clear is applied mid-cycle with strobes active to show that it acts without an edge and overrides everything, and the clear-then-add sequence is compared against a direct load of the same value.

// File: rtl/accum_pkg.sv
package accum_pkg;
  // Next-value choice made in front of the total register
  typedef enum logic [1:0] {
    NXT_KEEP = 2'd0,
    NXT_LOAD = 2'd1,
    NXT_SUM  = 2'd2
  } nxt_sel_e;
endpackage

// File: rtl/accum_fa_cell.sv
module accum_fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic ab_x;
  assign ab_x = a ^ b;
  assign s    = ab_x ^ ci;
  assign co   = (a & b) | (ab_x & ci);
endmodule

// File: rtl/accum_ripple.sv
module accum_ripple #(
  parameter int WIDTH     = 8,
  parameter bit USE_CELLS = 1'b1
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int CW = WIDTH + 1;

  generate
    if (USE_CELLS) begin : g_cells
      logic [CW-1:0] chain;
      assign chain[0] = 1'b0;  // R8: no carry into the lowest stage
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        accum_fa_cell u_fa (
          .a (a[i]),
          .b (b[i]),
          .ci(chain[i]),
          .s (sum[i]),
          .co(chain[i+1])
        );
      end
      assign cout = chain[WIDTH];
    end else begin : g_behav
      logic [CW-1:0] wide;
      assign wide = {1'b0, a} + {1'b0, b};
      assign sum  = wide[WIDTH-1:0];
      assign cout = wide[WIDTH];
    end
  endgenerate
endmodule

// File: rtl/accum_select.sv
module accum_select
  import accum_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             add_en,
  input  logic             load_en,
  input  logic [WIDTH-1:0] y,
  input  logic [WIDTH-1:0] sum,
  input  logic             sum_co,
  input  logic [WIDTH-1:0] cur,
  input  logic             cur_c,
  output logic [WIDTH-1:0] nxt,
  output logic             nxt_c
);
  nxt_sel_e sel;

  // load wins over add (R4)
  always_comb begin
    if (load_en)     sel = NXT_LOAD;
    else if (add_en) sel = NXT_SUM;
    else             sel = NXT_KEEP;
  end

  always_comb begin
    case (sel)
      NXT_LOAD: begin nxt = y;   nxt_c = 1'b0;   end
      NXT_SUM:  begin nxt = sum; nxt_c = sum_co; end
      default:  begin nxt = cur; nxt_c = cur_c;  end
    endcase
  end
endmodule

// File: rtl/accum_adder.sv
module accum_adder #(
  parameter int WIDTH     = 8,
  parameter bit USE_CELLS = 1'b1
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             add_en,
  input  logic             load_en,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] acc,
  output logic             carry
);
  localparam int CW = WIDTH + 1;

  logic [WIDTH-1:0] acc_q, sum_w, nxt_w;
  logic             c_q, co_w, nxt_c_w;

  accum_ripple #(.WIDTH(WIDTH), .USE_CELLS(USE_CELLS)) u_add (
    .a   (acc_q),
    .b   (y),
    .sum (sum_w),
    .cout(co_w)
  );

  accum_select #(.WIDTH(WIDTH)) u_sel (
    .add_en (add_en),
    .load_en(load_en),
    .y      (y),
    .sum    (sum_w),
    .sum_co (co_w),
    .cur    (acc_q),
    .cur_c  (c_q),
    .nxt    (nxt_w),
    .nxt_c  (nxt_c_w)
  );

  // Total and carry flag; clear acts without a clock edge (R1)
  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      acc_q <= '0;
      c_q   <= 1'b0;
    end else begin
      acc_q <= nxt_w;
      c_q   <= nxt_c_w;
    end
  end

  assign acc   = acc_q;
  assign carry = c_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk) clr |-> (acc == '0 && !carry)) else $error("clear"); // R9
  AST_LOAD_BYPASS: assert property (@(posedge clk) disable iff (clr) load_en |=> (acc == $past(y) && !carry)) else $error("load"); // R4
  AST_ADD_SUM: assert property (@(posedge clk) disable iff (clr) (add_en && !load_en) |=> ({carry, acc} == CW'({1'b0, $past(acc)} + {1'b0, $past(y)}))) else $error("add"); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr) (!add_en && !load_en) |=> ($stable(acc) && $stable(carry))) else $error("hold"); // R5
endmodule

// File: tb/accum_adder_bench.sv
module accum_adder_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr = 1'b1;
  logic         add_en = 1'b0;
  logic         load_en = 1'b0;
  logic [W-1:0] y = '0;
  logic [W-1:0] acc;
  logic         carry;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  accum_adder #(.WIDTH(W)) u_accum_adder (
    .clk(clk), .clr(clr), .add_en(add_en), .load_en(load_en),
    .y(y), .acc(acc), .carry(carry)
  );

  // {clr, load, add, y, expected acc, expected carry}
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {3'b001, 8'h25, 8'h25, 1'b0},  // R6 clear then add seeds total
    {3'b001, 8'h30, 8'h55, 1'b0},  // R2 plain add
    {3'b000, 8'hFF, 8'h55, 1'b0},  // R5 hold, live operand
    {3'b001, 8'hC0, 8'h15, 1'b1},  // R7 overflow
    {3'b000, 8'h3C, 8'h15, 1'b1},  // R5 carry held
    {3'b010, 8'h80, 8'h80, 1'b0},  // R3 load
    {3'b011, 8'h7F, 8'h7F, 1'b0},  // R4 load wins
    {3'b001, 8'h81, 8'h00, 1'b1},  // R7 sum exactly 2^W
    {3'b001, 8'hFF, 8'hFF, 1'b0},  // R2 carry cleared by add
    {3'b001, 8'h01, 8'h00, 1'b1},  // R8 full ripple chain
    {3'b010, 8'hAA, 8'hAA, 1'b0},  // R3 load clears carry
    {3'b001, 8'h55, 8'hFF, 1'b0},  // R8 no carry generated
    {3'b111, 8'h12, 8'h00, 1'b0},  // R9 clear overrides strobes
    {3'b001, 8'h3C, 8'h3C, 1'b0}   // R6 add after clear
  };

  task automatic check(input string req, input logic [W-1:0] ea, input logic ec);
    n_chk++;
    if (acc !== ea || carry !== ec) begin
      n_bad++;
      $display("FAIL %s: acc=%h carry=%b expected acc=%h carry=%b", req, acc, carry, ea, ec);
    end
  endtask

  initial begin
    #1;
    check("R1 clear at time zero", 8'h00, 1'b0);
    @(negedge clk);
    @(negedge clk);
    check("R9 edge during clear", 8'h00, 1'b0);
    clr = 1'b0;
    for (int i = 0; i < NV; i++) begin
      {clr, load_en, add_en, y} = VEC[i][19:9];
      @(negedge clk);
      check($sformatf("R%0s vector %0d", "vec", i), VEC[i][8:1], VEC[i][0]);
    end
    // directed: mid-cycle asynchronous clear
    {clr, load_en, add_en, y} = {3'b010, 8'hC3};
    @(negedge clk);
    check("R3 directed load", 8'hC3, 1'b0);
    {load_en, add_en, y} = {2'b01, 8'h77};
    #2 clr = 1'b1;
    #1 check("R1 clear without edge", 8'h00, 1'b0);
    @(negedge clk);
    clr = 1'b0;
    {load_en, add_en, y} = {2'b01, 8'h80};
    @(negedge clk);
    {load_en, add_en, y} = {2'b01, 8'h80};
    @(negedge clk);
    check("R7 two halves reach 2^W", 8'h00, 1'b1);
    {load_en, add_en, y} = {2'b00, 8'h00};
    @(negedge clk);
    check("R5 hold keeps carry", 8'h00, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: acc=%h carry=%b expected completion", acc, carry);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule